// File: doc/BRIEF.md
# Channel Group Capture Unit with Data-Available Marker

This block takes a snapshot of one group of input channels whenever its capture event fires, and holds the snapshot in a data register for a host to read. The capture event comes from one of two sources. The first is an active-low external strobe, which is asynchronous to the 16 MHz system clock and is synchronised here. The second is an internal periodic tick at one sixteenth of the system clock, which lets software look at the channels when no strobe arrives. Each group has its own strobe and its own copy of this unit.

Each capture can set a data-available marker. The host clears the marker by reading the data register, and it can see the marker at any time through a separate status output that has no side effect. The marker also drives an interrupt request, which is gated by an enable bit and held off while the internal tick is the source.

A capture that lands in the same cycle as a host read is not lost. It is parked in a one-entry pending slot. The marker stays low for two clocks, and then the parked data is posted. Switching the source from internal to external clears the marker and throws away any capture that is still moving through the synchroniser.

Top module: `cap_group_unit`

## Requirements
- R1: The external capture event is a high-to-low transition of `cap_strobe_n`. If the strobe is first sampled low at clock edge k, `data_out` shows every bit of `chan_in` together after edge k+2. The 2 comes from the `SYNC_STAGES` default of 2.
- R2: When `ctrl[0]` is 1, each capture sets `mark_status`. When `ctrl[0]` is 0, a capture still updates `data_out` and leaves `mark_status` as it was.
- R3: A one-cycle pulse on `rd_data_stb` with no capture in the same cycle clears `mark_status` at the next edge and leaves `data_out` unchanged.
- R4: While `rd_data_stb` stays low and the source does not change, reading `mark_status` any number of cycles does not alter it.
- R5: If a capture coincides with a read, `data_out` keeps its old value and the new snapshot is held pending.
- R6: In the pending case, `mark_status` is low for exactly two cycles after the read edge. At the following edge the pending data reaches `data_out`, and the marker is set if `ctrl[0]` is 1.
- R7: When `ctrl[1]` is 1, the internal tick is the source, and it captures once every `TICK_DIV` clocks (16 by default, which gives 1 MHz from 16 MHz).
- R8: A change of `ctrl[1]` from 1 to 0 clears `mark_status` at the next edge. Captures in that cycle and in the following `SYNC_STAGES` cycles are discarded.
- R9: `irq` equals `mark_status` AND `ctrl[2]`, and is forced low while `ctrl[1]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_in | input | NCH | Channel inputs of the group |
| cap_strobe_n | input | 1 | Asynchronous external capture strobe, active low |
| ctrl | input | 3 | bit0 marker enable, bit1 source select (1 internal, 0 external), bit2 interrupt enable |
| rd_data_stb | input | 1 | Host read of the data register (clears the marker) |
| data_out | output | NCH | Captured channel data |
| mark_status | output | 1 | Data-available marker, side-effect-free status |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the defaults: NCH=8, TICK_DIV=16 and SYNC_STAGES=2. With these values the strobe-to-data latency is exactly three edges, so a read can be placed by hand in the same cycle as a synchronised strobe. The bench then watches the two-cycle gap edge by edge. A tick period of 16 keeps a measurement of the full internal period short, and a two-stage synchroniser means the discard window after a source change lasts three cycles. A strobe placed right on the changeover falls inside that window.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_GAP1 = 2'd1,
    CAP_GAP2 = 2'd2
  } cap_state_t;
endpackage

// File: rtl/cap_strobe_sync.sv
module cap_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall_pulse
);
  // sr[0..STAGES-1] synchronise, sr[STAGES] holds the previous synchronised value
  logic [STAGES:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-1:0], strobe_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_d;
  end

  assign fall_pulse = sr_q[STAGES] & ~sr_q[STAGES-1];

  // R1: an edge produces a single-cycle pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/cap_tick_gen.sv
module cap_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: ticks never come back to back for a divider above one
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cap_marker_ctl.sv
module cap_marker_ctl
  import cap_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap,
  input  logic [NCH-1:0] chan,
  input  logic           rd,
  input  logic           mark_en,
  input  logic           force_clr,
  output logic [NCH-1:0] data_q,
  output logic           marker_q
);
  cap_state_t     st_q, st_d;
  logic [NCH-1:0] data_d, pend_q, pend_d;
  logic           marker_d;

  always_comb begin
    st_d     = st_q;
    data_d   = data_q;
    pend_d   = pend_q;
    marker_d = marker_q;
    if (force_clr) begin
      st_d     = CAP_IDLE;
      marker_d = 1'b0;
    end else begin
      unique case (st_q)
        CAP_IDLE: begin
          if (cap && rd) begin
            pend_d   = chan;
            marker_d = 1'b0;
            st_d     = CAP_GAP1;
          end else if (cap) begin
            data_d = chan;
            if (mark_en) marker_d = 1'b1;
          end else if (rd) begin
            marker_d = 1'b0;
          end
        end
        CAP_GAP1: begin
          if (cap) pend_d = chan;
          st_d = CAP_GAP2;
        end
        CAP_GAP2: begin
          data_d   = cap ? chan : pend_q;
          marker_d = mark_en;
          st_d     = CAP_IDLE;
        end
        default: st_d = CAP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CAP_IDLE;
      data_q   <= '0;
      pend_q   <= '0;
      marker_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      data_q   <= data_d;
      pend_q   <= pend_d;
      marker_q <= marker_d;
    end
  end

  // R3: a read without a capture leaves the marker clear
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !cap && st_q == CAP_IDLE) |=> !marker_q);
  // R5: the data register is frozen through the first gap cycle
  a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAP_GAP1) |=> $stable(data_q));
  // R6: the marker stays low across both gap cycles
  a_r6_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAP_GAP1 && !force_clr) |=> (st_q == CAP_GAP2 && !marker_q));
  // R4: with no read, capture or clear, the marker holds
  a_r4_marker_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAP_IDLE && !rd && !cap && !force_clr) |=> $stable(marker_q));
endmodule

// File: rtl/cap_group_unit.sv
module cap_group_unit #(
  parameter int NCH         = 8,
  parameter int TICK_DIV    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_in,
  input  logic           cap_strobe_n,
  input  logic [2:0]     ctrl,
  input  logic           rd_data_stb,
  output logic [NCH-1:0] data_out,
  output logic           mark_status,
  output logic           irq
);
  localparam int GW = $clog2(SYNC_STAGES + 1);

  logic          ext_pulse, tick;
  logic          sel_int, sel_q;
  logic          to_ext, guard_on, cap_ok;
  logic [GW-1:0] guard_q, guard_d;

  assign sel_int = ctrl[1];

  cap_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(cap_strobe_n), .fall_pulse(ext_pulse)
  );

  cap_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  assign to_ext   = sel_q & ~sel_int;
  assign guard_on = to_ext | (guard_q != '0);
  assign cap_ok   = (sel_int ? tick : ext_pulse) & ~guard_on;

  always_comb begin
    if (to_ext)             guard_d = GW'(SYNC_STAGES);
    else if (guard_q != '0) guard_d = guard_q - 1'b1;
    else                    guard_d = guard_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      guard_q <= '0;
    end else begin
      sel_q   <= sel_int;
      guard_q <= guard_d;
    end
  end

  cap_marker_ctl #(.NCH(NCH)) u_mark (
    .clk(clk), .rst_n(rst_n), .cap(cap_ok), .chan(chan_in),
    .rd(rd_data_stb), .mark_en(ctrl[0]), .force_clr(to_ext),
    .data_q(data_out), .marker_q(mark_status)
  );

  assign irq = mark_status & ctrl[2] & ~sel_int;

  // R8: a change to the external source leaves the marker clear
  a_r8_switch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !sel_int) |=> !mark_status);
  // R8: data is untouched in the cycle after the change
  a_r8_switch_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !sel_int) |=> $stable(data_out));
endmodule

// File: tb/tb_cap_group_unit.sv
module tb_cap_group_unit;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] chan_in;
  logic           cap_strobe_n;
  logic [2:0]     ctrl;
  logic           rd_data_stb;
  logic [NCH-1:0] data_out;
  logic           mark_status;
  logic           irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cap_group_unit #(.NCH(NCH), .TICK_DIV(16), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .cap_strobe_n(cap_strobe_n),
    .ctrl(ctrl), .rd_data_stb(rd_data_stb), .data_out(data_out),
    .mark_status(mark_status), .irq(irq)
  );

  // {chan[18:11], with_read[10], mark_en[9], exp_data[8:1], exp_mark[0]}
  localparam logic [18:0] VEC [0:5] = '{
    {8'hA5, 1'b0, 1'b1, 8'hA5, 1'b1},
    {8'h3C, 1'b0, 1'b1, 8'h3C, 1'b1},
    {8'h0F, 1'b1, 1'b1, 8'h0F, 1'b1},
    {8'hF0, 1'b0, 1'b0, 8'hF0, 1'b1},
    {8'h81, 1'b1, 1'b0, 8'h81, 1'b0},
    {8'h42, 1'b0, 1'b1, 8'h42, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // strobe low before edge P0; capture lands at P2; returns just after P2
  task automatic ext_cap(input logic [7:0] v, input bit with_rd);
    @(negedge clk); chan_in = v; cap_strobe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); if (with_rd) rd_data_stb = 1'b1;
    @(negedge clk); rd_data_stb = 1'b0; cap_strobe_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    int gap;
    rst_n = 1'b0; chan_in = '0; cap_strobe_n = 1'b1; ctrl = 3'b101; rd_data_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk("reset data", data_out, 0);
    chk("reset marker", mark_status, 0);
    chk("reset irq", irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    prev = 8'h00;
    for (int i = 0; i < 6; i++) begin
      ctrl = {1'b1, 1'b0, VEC[i][9]};
      ext_cap(VEC[i][18:11], VEC[i][10]);
      if (VEC[i][10]) begin
        chk("R5 data held on coincident read", data_out, prev);
        chk("R6 gap cycle 1 low", mark_status, 0);
        @(negedge clk);
        chk("R6 gap cycle 2 low", mark_status, 0);
        chk("R5 data held in gap", data_out, prev);
        @(negedge clk);
        chk("R6 posted data", data_out, VEC[i][8:1]);
        chk("R6 posted marker", mark_status, VEC[i][0]);
      end else begin
        chk("R1 capture data", data_out, VEC[i][8:1]);
        chk("R2 marker after capture", mark_status, VEC[i][0]);
      end
      chk("R9 irq follows marker", irq, VEC[i][0]);
      prev = VEC[i][8:1];
      repeat (3) @(negedge clk);
    end

    repeat (20) @(negedge clk);
    chk("R4 marker unchanged by status polling", mark_status, 1);
    ctrl = 3'b001;
    @(negedge clk);
    chk("R9 irq off when disabled", irq, 0);
    ctrl = 3'b101;
    rd_data_stb = 1'b1;
    @(negedge clk); rd_data_stb = 1'b0;
    chk("R3 read clears marker", mark_status, 0);
    chk("R3 read keeps data", data_out, 8'h42);

    chan_in = 8'h5A; ctrl = 3'b111;
    gap = 0;
    while (!mark_status && gap < 40) begin @(negedge clk); gap++; end
    chk("R7 internal capture data", data_out, 8'h5A);
    chk("R7 internal capture marker", mark_status, 1);
    chk("R9 irq suppressed on internal", irq, 0);
    rd_data_stb = 1'b1;
    @(negedge clk); rd_data_stb = 1'b0;
    gap = 1;
    while (!mark_status && gap < 40) begin @(negedge clk); gap++; end
    chk("R7 tick interval", gap, 16);

    @(negedge clk); ctrl = 3'b101; chan_in = 8'hC3; cap_strobe_n = 1'b0;
    @(negedge clk);
    chk("R8 changeover clears marker", mark_status, 0);
    @(negedge clk);
    @(negedge clk); cap_strobe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 strobe during changeover dropped", data_out, 8'h5A);
    chk("R8 marker stays clear", mark_status, 0);
    ext_cap(8'h66, 1'b0);
    chk("R1 capture after changeover", data_out, 8'h66);
    chk("R2 marker after changeover", mark_status, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule